// File: doc/BRIEF.md
# UART Byte Buffering with Receive Trigger

This block sits between a UART's host register interface and its serial shift logic. It holds outgoing bytes in a transmit queue and incoming bytes in a receive queue. Every received byte is stored together with its error flags, and the flags come out alongside the byte. A single write-only control byte turns both queues on or off and picks the receive fill level that raises the receive-data interrupt. The same byte can also issue one-shot flush commands for either direction.

With the queues off, each direction holds exactly one byte, and the interrupt simply reports that a received byte is waiting. When the line runs in multidrop mode, the receive side is held in this single-byte behaviour even if the queues are enabled. The transmit side is not affected by multidrop mode. Serial framing, baud generation and the shared-address status register are handled elsewhere.

Top module: `uart_fifo_buf`

## Requirements
- R1: After reset both queues are empty, the counts and overrun flags are 0, the queues are off, the trigger code is 00 and `rx_irq` is low.
- R2: A control write takes bit 0 as the queue enable and bits [7:6] as the trigger code. Bits [5:3] are ignored, so writing them changes neither the queue contents nor the trigger.
- R3: With the queues on, each queue holds up to DEPTH (16) bytes in first-in first-out order. It reports `full` at DEPTH entries and `empty` at 0, and reports the count in between.
- R4: A push into a full queue is dropped and sets that queue's sticky overrun flag. The flag is cleared only by reset, by an effective flush or by an enable change.
- R5: A pop from an empty queue leaves the count at 0 and keeps the previously popped value on the data output.
- R6: With the receive queue on, `rx_irq` is high exactly when the receive count is at least 1, 4, 8 or 14, for trigger codes 00, 01, 10 and 11 respectively.
- R7: With the queues off, each direction holds one byte: the count is 0 or 1 and `full` is high at 1. `rx_irq` is then high whenever a received byte is held, whatever the trigger code.
- R8: Writing control bit 2 as 1 together with bit 0 as 1 empties the transmit queue. The same bit written while bit 0 is 0, or bit 2 written as 0, leaves the transmit queue unchanged.
- R9: Writing control bit 1 as 1 together with bit 0 as 1, outside multidrop mode, empties the receive data and its error flags. Otherwise the receive queue is unchanged.
- R10: A flush and a push in the same cycle leave the queue empty. The flush bits are not held, so pushes after the flush write accumulate normally.
- R11: While `multidrop` is high, the receive side holds at most one byte even with the queues enabled. The transmit side keeps its full depth.
- R12: Any change of a direction's effective enable empties that queue and clears its overrun flag. This includes a control write toggling bit 0, or `multidrop` changing for the receive side.
- R13: The error flags pushed with a received byte appear on `host_rx_err` together with that byte on `host_rx_data`, one cycle after the pop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Control byte write strobe |
| cfg_wdata | input | 8 | Control byte value |
| multidrop | input | 1 | Multidrop line mode; forces single-byte receive |
| host_tx_push | input | 1 | Host writes a byte to transmit |
| host_tx_data | input | 8 | Byte to transmit |
| tx_full | output | 1 | Transmit queue full |
| tx_empty | output | 1 | Transmit queue empty |
| tx_count | output | 5 | Transmit fill count |
| tx_overrun | output | 1 | Sticky transmit overrun flag |
| ser_tx_pop | input | 1 | Shift logic takes the next byte |
| ser_tx_data | output | 8 | Byte taken by the last transmit pop |
| ser_rx_push | input | 1 | Shift logic delivers a received byte |
| ser_rx_data | input | 8 | Received byte |
| ser_rx_err | input | 3 | Error flags of the received byte |
| rx_full | output | 1 | Receive queue full |
| rx_empty | output | 1 | Receive queue empty |
| rx_count | output | 5 | Receive fill count |
| rx_overrun | output | 1 | Sticky receive overrun flag |
| host_rx_pop | input | 1 | Host reads a received byte |
| host_rx_data | output | 8 | Byte from the last receive pop |
| host_rx_err | output | 3 | Error flags of that byte |
| rx_irq | output | 1 | Receive-data interrupt |

## Verification
Counts, full, empty, overrun flags and `rx_irq` all change at the clock edge that samples the push, pop or control write, because they depend only on registered state. Popped data and error flags are registered and appear after the edge that accepts the pop. The bench drives every stimulus on a falling edge and samples at the next falling edge, so each result is read one half-period after the edge that produced it. Trigger checks are made after every single receive push, which pins the exact count at which the interrupt rises.

// File: rtl/uart_fifo_pkg.sv
package uart_fifo_pkg;

    localparam int DATA_W = 8;
    localparam int ERR_W  = 3;

    // control byte bit positions (decoded by the configuration stage)
    localparam int CB_ON     = 0;
    localparam int CB_RXCLR  = 1;
    localparam int CB_TXCLR  = 2;
    localparam int CB_RSV_LO = 3;
    localparam int CB_RSV_HI = 5;
    localparam int CB_TRIG   = 6;

    typedef enum logic [1:0] {
        TRIG_1  = 2'b00,
        TRIG_4  = 2'b01,
        TRIG_8  = 2'b10,
        TRIG_14 = 2'b11
    } rx_trig_e;

    typedef struct packed {
        rx_trig_e trig;
        logic     fifo_on;
    } fifo_cfg_t;

    typedef struct packed {
        logic tx_on_nx;
        logic rx_on_nx;
        logic tx_clr;
        logic rx_clr;
    } fifo_cmd_t;

    typedef struct packed {
        logic [ERR_W-1:0]  err;
        logic [DATA_W-1:0] data;
    } rx_entry_t;

    function automatic int unsigned trig_bytes(rx_trig_e t, int unsigned depth);
        int unsigned n;
        case (t)
            TRIG_1:  n = 1;
            TRIG_4:  n = 4;
            TRIG_8:  n = 8;
            default: n = 14;
        endcase
        return (n > depth) ? depth : n;
    endfunction

endpackage

// File: rtl/uart_fifo_cfg.sv
module uart_fifo_cfg
    import uart_fifo_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [7:0]        wdata,
    input  logic              multidrop,
    output fifo_cfg_t         cfg,
    output fifo_cmd_t         cmd
);

    logic [CB_RSV_HI-CB_RSV_LO:0] rsv_unused;
    logic                         on_nx;

    assign rsv_unused = wdata[CB_RSV_HI:CB_RSV_LO];
    assign on_nx      = wr ? wdata[CB_ON] : cfg.fifo_on;

    always_comb begin
        cmd.tx_on_nx = on_nx;
        cmd.rx_on_nx = on_nx & ~multidrop;
        cmd.tx_clr   = wr & wdata[CB_TXCLR] & wdata[CB_ON];
        cmd.rx_clr   = wr & wdata[CB_RXCLR] & wdata[CB_ON] & ~multidrop;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg.fifo_on <= 1'b0;
            cfg.trig    <= TRIG_1;
        end else if (wr) begin
            cfg.fifo_on <= wdata[CB_ON];
            cfg.trig    <= rx_trig_e'(wdata[CB_TRIG+1:CB_TRIG]);
        end
    end

endmodule

// File: rtl/uart_byte_fifo.sv
module uart_byte_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 16
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         on_nx,
    input  logic                         clr,
    input  logic                         push,
    input  logic [W-1:0]                 push_data,
    input  logic                         pop,
    output logic [W-1:0]                 pop_data,
    output logic                         full,
    output logic                         empty,
    output logic [$clog2(DEPTH+1)-1:0]   count,
    output logic                         overrun,
    output logic                         on
);

    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] cap;
    logic             wipe, pop_ok, push_ok;

    function automatic logic [PTR_W-1:0] adv(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign cap   = on ? CNT_W'(DEPTH) : CNT_W'(1);
    assign full  = (count >= cap);
    assign empty = (count == '0);

    always_comb begin
        wipe    = clr | (on_nx != on);
        pop_ok  = !wipe && pop && !empty;
        push_ok = !wipe && push && (!full || pop_ok);
    end

    always_ff @(posedge clk) begin
        if (push_ok) begin
            mem[wr_ptr] <= push_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            on       <= 1'b0;
            wr_ptr   <= '0;
            rd_ptr   <= '0;
            count    <= '0;
            pop_data <= '0;
            overrun  <= 1'b0;
        end else begin
            on <= on_nx;
            if (wipe) begin
                wr_ptr  <= '0;
                rd_ptr  <= '0;
                count   <= '0;
                overrun <= 1'b0;
            end else begin
                if (push_ok) begin
                    wr_ptr <= adv(wr_ptr);
                end
                if (pop_ok) begin
                    rd_ptr   <= adv(rd_ptr);
                    pop_data <= mem[rd_ptr];
                end
                case ({push_ok, pop_ok})
                    2'b10:   count <= count + 1'b1;
                    2'b01:   count <= count - 1'b1;
                    default: count <= count;
                endcase
                if (push && !push_ok) begin
                    overrun <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/uart_rx_trigger.sv
module uart_rx_trigger
    import uart_fifo_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic [$clog2(DEPTH+1)-1:0] count,
    input  logic                       on,
    input  rx_trig_e                   trig,
    output logic                       irq
);

    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [CNT_W-1:0] thr;

    always_comb begin
        thr = on ? CNT_W'(trig_bytes(trig, DEPTH)) : CNT_W'(1);
        irq = (count >= thr);
    end

endmodule

// File: rtl/uart_fifo_buf.sv
module uart_fifo_buf
    import uart_fifo_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       cfg_wr,
    input  logic [7:0]                 cfg_wdata,
    input  logic                       multidrop,
    input  logic                       host_tx_push,
    input  logic [DATA_W-1:0]          host_tx_data,
    output logic                       tx_full,
    output logic                       tx_empty,
    output logic [$clog2(DEPTH+1)-1:0] tx_count,
    output logic                       tx_overrun,
    input  logic                       ser_tx_pop,
    output logic [DATA_W-1:0]          ser_tx_data,
    input  logic                       ser_rx_push,
    input  logic [DATA_W-1:0]          ser_rx_data,
    input  logic [ERR_W-1:0]           ser_rx_err,
    output logic                       rx_full,
    output logic                       rx_empty,
    output logic [$clog2(DEPTH+1)-1:0] rx_count,
    output logic                       rx_overrun,
    input  logic                       host_rx_pop,
    output logic [DATA_W-1:0]          host_rx_data,
    output logic [ERR_W-1:0]           host_rx_err,
    output logic                       rx_irq
);

    localparam int RX_W = $bits(rx_entry_t);

    fifo_cfg_t  cfg;
    fifo_cmd_t  cmd;
    rx_entry_t  rx_in, rx_out;
    logic       tx_on, rx_on;

    uart_fifo_cfg i_cfg (
        .clk       (clk),
        .rst       (rst),
        .wr        (cfg_wr),
        .wdata     (cfg_wdata),
        .multidrop (multidrop),
        .cfg       (cfg),
        .cmd       (cmd)
    );

    uart_byte_fifo #(.W(DATA_W), .DEPTH(DEPTH)) i_tx_q (
        .clk       (clk),
        .rst       (rst),
        .on_nx     (cmd.tx_on_nx),
        .clr       (cmd.tx_clr),
        .push      (host_tx_push),
        .push_data (host_tx_data),
        .pop       (ser_tx_pop),
        .pop_data  (ser_tx_data),
        .full      (tx_full),
        .empty     (tx_empty),
        .count     (tx_count),
        .overrun   (tx_overrun),
        .on        (tx_on)
    );

    assign rx_in.data   = ser_rx_data;
    assign rx_in.err    = ser_rx_err;
    assign host_rx_data = rx_out.data;
    assign host_rx_err  = rx_out.err;

    uart_byte_fifo #(.W(RX_W), .DEPTH(DEPTH)) i_rx_q (
        .clk       (clk),
        .rst       (rst),
        .on_nx     (cmd.rx_on_nx),
        .clr       (cmd.rx_clr),
        .push      (ser_rx_push),
        .push_data (rx_in),
        .pop       (host_rx_pop),
        .pop_data  (rx_out),
        .full      (rx_full),
        .empty     (rx_empty),
        .count     (rx_count),
        .overrun   (rx_overrun),
        .on        (rx_on)
    );

    uart_rx_trigger #(.DEPTH(DEPTH)) i_trig (
        .count (rx_count),
        .on    (rx_on),
        .trig  (cfg.trig),
        .irq   (rx_irq)
    );

endmodule

// File: rtl/uart_fifo_buf_chk.sv
module uart_fifo_buf_chk #(
    parameter int DEPTH = 16
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       cfg_wr,
    input logic [7:0]                 cfg_wdata,
    input logic                       multidrop,
    input logic                       host_tx_push,
    input logic                       tx_full,
    input logic                       tx_empty,
    input logic [$clog2(DEPTH+1)-1:0] tx_count,
    input logic                       tx_overrun,
    input logic                       ser_rx_push,
    input logic                       rx_full,
    input logic                       rx_empty,
    input logic [$clog2(DEPTH+1)-1:0] rx_count,
    input logic                       host_rx_pop,
    input logic [7:0]                 host_rx_data,
    input logic                       rx_irq
);

    p_count_bound_r3: assert property (@(posedge clk) disable iff (rst)
        (int'(tx_count) <= DEPTH) && (int'(rx_count) <= DEPTH));

    p_full_not_empty_r3: assert property (@(posedge clk) disable iff (rst)
        !(tx_full && tx_empty) && !(rx_full && rx_empty));

    p_overrun_cause_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_overrun) |-> $past(host_tx_push && tx_full));

    p_empty_pop_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (host_rx_pop && rx_empty && !ser_rx_push) |=> $stable(host_rx_data) && rx_empty);

    p_no_irq_when_empty_r6: assert property (@(posedge clk) disable iff (rst)
        rx_empty |-> !rx_irq);

    p_tx_flush_r8: assert property (@(posedge clk) disable iff (rst)
        (cfg_wr && cfg_wdata[2] && cfg_wdata[0]) |=> tx_empty);

    p_rx_flush_r9: assert property (@(posedge clk) disable iff (rst)
        (cfg_wr && cfg_wdata[1] && cfg_wdata[0] && !multidrop) |=> rx_empty);

    p_multidrop_single_r11: assert property (@(posedge clk) disable iff (rst)
        (multidrop && $past(multidrop)) |-> (int'(rx_count) <= 1));

endmodule

bind uart_fifo_buf uart_fifo_buf_chk #(.DEPTH(DEPTH)) i_chk (
    .clk          (clk),
    .rst          (rst),
    .cfg_wr       (cfg_wr),
    .cfg_wdata    (cfg_wdata),
    .multidrop    (multidrop),
    .host_tx_push (host_tx_push),
    .tx_full      (tx_full),
    .tx_empty     (tx_empty),
    .tx_count     (tx_count),
    .tx_overrun   (tx_overrun),
    .ser_rx_push  (ser_rx_push),
    .rx_full      (rx_full),
    .rx_empty     (rx_empty),
    .rx_count     (rx_count),
    .host_rx_pop  (host_rx_pop),
    .host_rx_data (host_rx_data),
    .rx_irq       (rx_irq)
);

// File: tb/test_uart_fifo_buf.sv
module test_uart_fifo_buf;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_wr = 1'b0;
    logic [7:0] cfg_wdata = '0;
    logic       multidrop = 1'b0;
    logic       host_tx_push = 1'b0;
    logic [7:0] host_tx_data = '0;
    logic       tx_full, tx_empty, tx_overrun;
    logic [4:0] tx_count;
    logic       ser_tx_pop = 1'b0;
    logic [7:0] ser_tx_data;
    logic       ser_rx_push = 1'b0;
    logic [7:0] ser_rx_data = '0;
    logic [2:0] ser_rx_err = '0;
    logic       rx_full, rx_empty, rx_overrun;
    logic [4:0] rx_count;
    logic       host_rx_pop = 1'b0;
    logic [7:0] host_rx_data;
    logic [2:0] host_rx_err;
    logic       rx_irq;

    int vectors = 0;
    int miscompares = 0;

    always #2 clk = ~clk;

    uart_fifo_buf #(.DEPTH(16)) i_uart_fifo_buf (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .multidrop(multidrop),
        .host_tx_push(host_tx_push), .host_tx_data(host_tx_data),
        .tx_full(tx_full), .tx_empty(tx_empty), .tx_count(tx_count), .tx_overrun(tx_overrun),
        .ser_tx_pop(ser_tx_pop), .ser_tx_data(ser_tx_data),
        .ser_rx_push(ser_rx_push), .ser_rx_data(ser_rx_data), .ser_rx_err(ser_rx_err),
        .rx_full(rx_full), .rx_empty(rx_empty), .rx_count(rx_count), .rx_overrun(rx_overrun),
        .host_rx_pop(host_rx_pop), .host_rx_data(host_rx_data), .host_rx_err(host_rx_err),
        .rx_irq(rx_irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic ctrl_write(input logic [7:0] v);
        cfg_wr = 1'b1; cfg_wdata = v;
        @(negedge clk);
        cfg_wr = 1'b0; cfg_wdata = '0;
    endtask

    task automatic tx_put(input logic [7:0] d);
        host_tx_push = 1'b1; host_tx_data = d;
        @(negedge clk);
        host_tx_push = 1'b0;
    endtask

    task automatic tx_get(output logic [7:0] d);
        ser_tx_pop = 1'b1;
        @(negedge clk);
        ser_tx_pop = 1'b0;
        d = ser_tx_data;
    endtask

    task automatic rx_put(input logic [7:0] d, input logic [2:0] e);
        ser_rx_push = 1'b1; ser_rx_data = d; ser_rx_err = e;
        @(negedge clk);
        ser_rx_push = 1'b0;
    endtask

    task automatic rx_get(output logic [7:0] d, output logic [2:0] e);
        host_rx_pop = 1'b1;
        @(negedge clk);
        host_rx_pop = 1'b0;
        d = host_rx_data; e = host_rx_err;
    endtask

    task automatic t_reset();
        chk("R1 tx_empty", 32'(tx_empty), 1);
        chk("R1 rx_empty", 32'(rx_empty), 1);
        chk("R1 tx_count", 32'(tx_count), 0);
        chk("R1 rx_count", 32'(rx_count), 0);
        chk("R1 overruns", 32'({tx_overrun, rx_overrun}), 0);
        chk("R1 rx_irq", 32'(rx_irq), 0);
    endtask

    task automatic t_single_byte();
        logic [7:0] d;
        logic [2:0] e;
        tx_put(8'hA1);
        chk("R7 tx full at one byte", 32'(tx_full), 1);
        tx_put(8'hA2);
        chk("R7 tx count held at 1", 32'(tx_count), 1);
        chk("R4 tx overrun in single mode", 32'(tx_overrun), 1);
        tx_get(d);
        chk("R7 tx single byte value", 32'(d), 32'hA1);
        tx_get(d);
        chk("R5 empty pop keeps value", 32'(d), 32'hA1);
        chk("R5 empty pop count", 32'(tx_count), 0);
        ctrl_write(8'hC0);
        chk("R7 irq low when no byte", 32'(rx_irq), 0);
        rx_put(8'h55, 3'b000);
        chk("R7 irq with held byte ignores trigger", 32'(rx_irq), 1);
        rx_get(d, e);
        chk("R7 rx single byte value", 32'(d), 32'h55);
        chk("R7 irq drops after pop", 32'(rx_irq), 0);
    endtask

    task automatic t_fifo_order();
        logic [7:0] d;
        ctrl_write(8'h01);
        chk("R12 enable empties tx", 32'(tx_empty), 1);
        chk("R12 enable clears overrun", 32'(tx_overrun), 0);
        for (int i = 0; i < 16; i++) tx_put(8'(i * 7 + 3));
        chk("R3 count at depth", 32'(tx_count), 16);
        chk("R3 full at depth", 32'(tx_full), 1);
        tx_put(8'hEE);
        chk("R4 overrun on full push", 32'(tx_overrun), 1);
        chk("R4 dropped push keeps count", 32'(tx_count), 16);
        for (int i = 0; i < 16; i++) begin
            tx_get(d);
            chk("R3 fifo order", 32'(d), 32'(8'(i * 7 + 3)));
        end
        chk("R3 empty after drain", 32'(tx_empty), 1);
        tx_get(d);
        chk("R5 empty pop keeps last", 32'(d), 32'(8'(15 * 7 + 3)));
        chk("R4 overrun sticky", 32'(tx_overrun), 1);
    endtask

    task automatic t_trigger();
        int lvl;
        for (int code = 0; code < 4; code++) begin
            lvl = (code == 0) ? 1 : (code == 1) ? 4 : (code == 2) ? 8 : 14;
            ctrl_write({2'(code), 3'b000, 3'b011});
            chk("R9 flush before trigger run", 32'(rx_empty), 1);
            for (int k = 1; k <= 14; k++) begin
                rx_put(8'(k), 3'b000);
                chk($sformatf("R6 irq code %0d count %0d", code, k), 32'(rx_irq), 32'(k >= lvl));
            end
        end
    endtask

    task automatic t_error_flags();
        logic [7:0] d;
        logic [2:0] e;
        ctrl_write(8'h03);
        rx_put(8'h11, 3'b101);
        rx_put(8'h22, 3'b010);
        rx_put(8'h33, 3'b000);
        rx_get(d, e);
        chk("R13 data with flags", 32'(d), 32'h11);
        chk("R13 flags with data", 32'(e), 32'b101);
        ctrl_write(8'h03);
        chk("R9 flush empties rx", 32'(rx_count), 0);
        chk("R9 irq low after flush", 32'(rx_irq), 0);
        rx_put(8'h44, 3'b011);
        rx_get(d, e);
        chk("R9 data after flush", 32'(d), 32'h44);
        chk("R9 error queue flushed too", 32'(e), 32'b011);
    endtask

    task automatic t_flush_gate();
        logic [7:0] d;
        logic [2:0] e;
        ctrl_write(8'h00);
        tx_put(8'h9A);
        ctrl_write(8'h04);
        chk("R8 tx flush gated when off", 32'(tx_count), 1);
        tx_get(d);
        chk("R8 gated byte survives", 32'(d), 32'h9A);
        rx_put(8'h5C, 3'b001);
        ctrl_write(8'h02);
        chk("R9 rx flush gated when off", 32'(rx_count), 1);
        rx_get(d, e);
        chk("R9 gated rx byte survives", 32'(d), 32'h5C);
    endtask

    task automatic t_flush_push();
        ctrl_write(8'h01);
        tx_put(8'h01); tx_put(8'h02); tx_put(8'h03);
        ctrl_write(8'h01);
        chk("R8 bit2 zero no effect", 32'(tx_count), 3);
        cfg_wr = 1'b1; cfg_wdata = 8'h05;
        host_tx_push = 1'b1; host_tx_data = 8'h77;
        @(negedge clk);
        cfg_wr = 1'b0; cfg_wdata = '0; host_tx_push = 1'b0;
        chk("R10 flush with push leaves empty", 32'(tx_empty), 1);
        tx_put(8'h04); tx_put(8'h05); tx_put(8'h06);
        chk("R10 flush not retained", 32'(tx_count), 3);
    endtask

    task automatic t_multidrop();
        multidrop = 1'b1;
        @(negedge clk);
        rx_put(8'hA0, 3'b000);
        rx_put(8'hA1, 3'b000);
        chk("R11 rx capped at one", 32'(rx_count), 1);
        chk("R11 rx full in multidrop", 32'(rx_full), 1);
        chk("R11 rx overrun in multidrop", 32'(rx_overrun), 1);
        tx_put(8'h07);
        chk("R11 tx keeps depth", 32'(tx_count), 4);
        chk("R11 tx not full", 32'(tx_full), 0);
        multidrop = 1'b0;
        @(negedge clk);
        chk("R12 multidrop change empties rx", 32'(rx_count), 0);
        chk("R12 multidrop change clears overrun", 32'(rx_overrun), 0);
        chk("R12 tx unaffected by multidrop", 32'(tx_count), 4);
    endtask

    task automatic t_reserved();
        ctrl_write(8'h39);
        chk("R2 reserved bits no effect on tx", 32'(tx_count), 4);
        rx_put(8'h10, 3'b000);
        chk("R2 trigger 00 after write", 32'(rx_irq), 1);
        ctrl_write(8'h79);
        chk("R2 trigger 01 from bits 7:6", 32'(rx_irq), 0);
        chk("R2 rx kept through write", 32'(rx_count), 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_single_byte();
        t_fifo_order();
        t_trigger();
        t_error_flags();
        t_flush_gate();
        t_flush_push();
        t_multidrop();
        t_reserved();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        vectors++;
        miscompares++;
        $display("FAIL watchdog: all requirements, actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule